// File: doc/BRIEF.md
# Doorbell Signalling Interrupt Controller

This block lets processors on a chip ring doorbells at one another. Each doorbell is named by a 32-bit identifier word. The upper half of the word holds the client number and the lower half holds the signal number. A write of such a word to the transmit register produces a one-cycle request toward that client and signal. On the receiving side there is a fixed table of (client, signal) slots. Each incoming doorbell line sets a pending bit for its slot.

Software controls each slot by writing the slot's identifier word to one of several command registers: unmask, mask and acknowledge. A separate flush register drops every pending doorbell at once. A single active-high, level-sensitive interrupt stays asserted while any unmasked slot is pending. The service routine reads the query register to get the identifier of one ready slot. It acknowledges that slot and reads again, and it stops when the all-ones word comes back.

The slot table is computed rather than stored. Slot `s` belongs to client `s / SIGS_PER_CLIENT` and signal `s % SIGS_PER_CLIENT`. With the defaults there are 6 clients with 8 signals each, which gives 48 slots.

Top module: `doorbell_irq_ctrl`

## Requirements
- R1: An identifier word carries the client number in bits 31:16 and the signal number in bits 15:0. Slot `s` answers to client `s / SIGS_PER_CLIENT` and signal `s % SIGS_PER_CLIENT`, so incoming line `sigIn[13]` is reported as 0x00010005.
- R2: A write to offset 0x0C raises `sendStrobe` for exactly one cycle, on the cycle after the write, with `sendId` equal to the written word. `sendStrobe` is low in every other cycle.
- R3: A read of offset 0x10 returns, one cycle later on `rdata`, the identifier of the lowest-numbered slot that is both pending and unmasked. When no such slot exists it returns 0xFFFFFFFF.
- R4: Writing an identifier to offset 0x1C clears the pending bit of that slot only. The change takes effect from the next cycle.
- R5: Writing an identifier to offset 0x14 unmasks that slot, and writing it to offset 0x18 masks it. No other slot's mask changes.
- R6: `irqOut` is high exactly while at least one slot is both pending and unmasked.
- R7: A doorbell that arrives on a masked slot stays pending without raising `irqOut`. It raises `irqOut` once the slot is unmasked.
- R8: A write of any value to offset 0x38 clears all pending bits and leaves every mask unchanged.
- R9: Unmask, mask and acknowledge writes that carry an identifier matching no slot change nothing. For example, client 6 or signal 8 do not exist with the defaults.
- R10: When an incoming doorbell and a clear of the same slot (acknowledge or flush) land in the same cycle, the slot stays pending.
- R11: Reset clears every pending bit and masks every slot, so `irqOut` is low and a query returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rdEn`; unmapped offsets read 0 |
| sigIn | input | NUM_CLIENTS*SIGS_PER_CLIENT | Incoming doorbell lines, one per slot, each high for one cycle per event |
| sendStrobe | output | 1 | Outgoing doorbell request pulse |
| sendId | output | 32 | Identifier word of the outgoing request |
| irqOut | output | 1 | Level summary interrupt, active high |

## Verification
A pending or mask bit held in the wrong state shows on the ports within one cycle. It shows either as a wrong level on `irqOut` or as the wrong identifier, or the all-ones word, in the query result read back on the next cycle. The bench therefore follows every command with a query or an interrupt sample. Because the query always reports the lowest ready slot, the stimulus leaves several slots pending at once. A wrongly cleared high-numbered slot is then exposed as soon as the lower ones are acknowledged. Identifiers that a naive multiply-and-add decode would alias onto real slots, such as client 1 signal 8, show whether unknown commands leak into the table.

// File: rtl/doorbell_pkg.sv
`timescale 1ns/1ps
package doorbell_pkg;
  localparam int BUS_ADDR_W = 8;
  localparam int ID_W       = 32;
  localparam int HALF_W     = ID_W / 2;

  localparam logic [BUS_ADDR_W-1:0] OFF_SEND  = 8'h0C;
  localparam logic [BUS_ADDR_W-1:0] OFF_QUERY = 8'h10;
  localparam logic [BUS_ADDR_W-1:0] OFF_UNMSK = 8'h14;
  localparam logic [BUS_ADDR_W-1:0] OFF_MASK  = 8'h18;
  localparam logic [BUS_ADDR_W-1:0] OFF_ACK   = 8'h1C;
  localparam logic [BUS_ADDR_W-1:0] OFF_FLUSH = 8'h38;

  // Command strobes from the register decode to the slot table
  typedef struct packed {
    logic            setEn;
    logic            setDis;
    logic            clrOne;
    logic            clrAll;
    logic [ID_W-1:0] id;
  } strobeT;
endpackage

// File: rtl/doorbell_ctrl.sv
`timescale 1ns/1ps
module doorbell_ctrl
  import doorbell_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]       wdata,
  input  logic [ID_W-1:0]       queryId,
  output strobeT                stb,
  output logic [ID_W-1:0]       rdata,
  output logic                  sendStrobe,
  output logic [ID_W-1:0]       sendId
);
  // Combinational command decode; the table registers the effect
  always_comb begin
    stb        = '0;
    stb.id     = wdata;
    stb.setEn  = wrEn && (addr == OFF_UNMSK);
    stb.setDis = wrEn && (addr == OFF_MASK);
    stb.clrOne = wrEn && (addr == OFF_ACK);
    stb.clrAll = wrEn && (addr == OFF_FLUSH);
  end

  logic sendHit;
  assign sendHit = wrEn && (addr == OFF_SEND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendStrobe <= 1'b0;
      sendId     <= '0;
    end else begin
      sendStrobe <= sendHit;
      if (sendHit) sendId <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (rdEn) begin
      rdata <= (addr == OFF_QUERY) ? queryId : '0;
    end
  end
endmodule

// File: rtl/doorbell_dpath.sv
`timescale 1ns/1ps
module doorbell_dpath
  import doorbell_pkg::*;
#(
  parameter int NUM_CLIENTS     = 6,
  parameter int SIGS_PER_CLIENT = 8,
  parameter int NUM_SLOTS       = NUM_CLIENTS * SIGS_PER_CLIENT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [NUM_SLOTS-1:0] sigIn,
  output logic [NUM_SLOTS-1:0] pendVec,
  output logic [NUM_SLOTS-1:0] enVec,
  output logic [ID_W-1:0]      queryId,
  output logic                 irqOut
);
  logic [HALF_W-1:0]    cmdClient, cmdSignal;
  logic [NUM_SLOTS-1:0] hit, live;
  logic [ID_W-1:0]      slotId [NUM_SLOTS];

  assign cmdClient = stb.id[ID_W-1:HALF_W];
  assign cmdSignal = stb.id[HALF_W-1:0];

  // Each slot matches its own exact identifier; anything else hits nothing
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int CL = s / SIGS_PER_CLIENT;
    localparam int SG = s % SIGS_PER_CLIENT;
    assign slotId[s] = {HALF_W'(CL), HALF_W'(SG)};
    assign hit[s]    = (cmdClient == HALF_W'(CL)) && (cmdSignal == HALF_W'(SG));
  end

  logic [NUM_SLOTS-1:0] pendNext, enNext;

  always_comb begin
    pendNext = pendVec;
    if (stb.clrOne) pendNext = pendNext & ~hit;
    if (stb.clrAll) pendNext = '0;
    pendNext = pendNext | sigIn;      // arrival beats a same-cycle clear
    enNext = enVec;
    if (stb.setEn)  enNext = enNext | hit;
    if (stb.setDis) enNext = enNext & ~hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec <= '0;
      enVec   <= '0;
    end else begin
      pendVec <= pendNext;
      enVec   <= enNext;
    end
  end

  assign live   = pendVec & enVec;
  assign irqOut = |live;

  // Fixed priority: lowest slot wins
  always_comb begin
    queryId = '1;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (live[s]) queryId = slotId[s];
    end
  end
endmodule

// File: rtl/doorbell_irq_ctrl.sv
`timescale 1ns/1ps
module doorbell_irq_ctrl
  import doorbell_pkg::*;
#(
  parameter int NUM_CLIENTS     = 6,
  parameter int SIGS_PER_CLIENT = 8,
  localparam int NUM_SLOTS      = NUM_CLIENTS * SIGS_PER_CLIENT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]       wdata,
  output logic [ID_W-1:0]       rdata,
  input  logic [NUM_SLOTS-1:0]  sigIn,
  output logic                  sendStrobe,
  output logic [ID_W-1:0]       sendId,
  output logic                  irqOut
);
  strobeT               stb;
  logic [ID_W-1:0]      queryId;
  logic [NUM_SLOTS-1:0] pendVec, enVec;

  doorbell_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .queryId(queryId), .stb(stb), .rdata(rdata),
    .sendStrobe(sendStrobe), .sendId(sendId)
  );

  doorbell_dpath #(
    .NUM_CLIENTS(NUM_CLIENTS), .SIGS_PER_CLIENT(SIGS_PER_CLIENT), .NUM_SLOTS(NUM_SLOTS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sigIn(sigIn), .pendVec(pendVec),
    .enVec(enVec), .queryId(queryId), .irqOut(irqOut)
  );
endmodule

// File: rtl/doorbell_checker.sv
`timescale 1ns/1ps
module doorbell_checker
  import doorbell_pkg::*;
#(
  parameter int NUM_SLOTS = 48
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [BUS_ADDR_W-1:0] addr,
  input logic [ID_W-1:0]       wdata,
  input logic [ID_W-1:0]       rdata,
  input logic [NUM_SLOTS-1:0]  sigIn,
  input logic                  sendStrobe,
  input logic [ID_W-1:0]       sendId,
  input logic                  irqOut,
  input logic [NUM_SLOTS-1:0]  pendVec
);
  p_send_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_SEND) |=> (sendStrobe && sendId == $past(wdata)));

  p_send_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == OFF_SEND) |=> !sendStrobe);

  p_empty_query_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_QUERY && !irqOut) |=> (rdata == '1));

  p_busy_query_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_QUERY && irqOut) |=> (rdata != '1));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_FLUSH) |=> ((pendVec & ~$past(sigIn)) == '0));

  p_arrival_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|sigIn) |=> ((pendVec & $past(sigIn)) == $past(sigIn)));
endmodule

bind doorbell_irq_ctrl doorbell_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
  .rdata(rdata), .sigIn(sigIn), .sendStrobe(sendStrobe), .sendId(sendId),
  .irqOut(irqOut), .pendVec(pendVec)
);

// File: tb/doorbell_irq_ctrl_tb.sv
`timescale 1ns/1ps
module doorbell_irq_ctrl_tb_top;
  localparam int NC  = 6;
  localparam int SPC = 8;
  localparam int NS  = NC * SPC;
  localparam logic [7:0] A_SEND = 8'h0C, A_QRY = 8'h10, A_EN = 8'h14,
                         A_DIS = 8'h18, A_ACK = 8'h1C, A_FLUSH = 8'h38;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] sigIn = '0;
  logic          sendStrobe, irqOut;
  logic [31:0]   sendId;

  int checks = 0;
  int errors = 0;

  logic [NS-1:0] mPend = '0, mEn = '0;
  logic [31:0]   expQ[$];
  string         tagQ[$];
  logic          rdSeen = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  doorbell_irq_ctrl #(.NUM_CLIENTS(NC), .SIGS_PER_CLIENT(SPC)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sigIn(sigIn), .sendStrobe(sendStrobe), .sendId(sendId),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] idOf(int s);
    return {16'(s / SPC), 16'(s % SPC)};
  endfunction

  function automatic int slotOf(logic [31:0] id);
    if (id[31:16] >= 16'(NC) || id[15:0] >= 16'(SPC)) return -1;
    return int'(id[31:16]) * SPC + int'(id[15:0]);
  endfunction

  function automatic logic [31:0] expQuery();
    for (int s = 0; s < NS; s++) if (mPend[s] && mEn[s]) return idOf(s);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(string tag);
    chk(tag, {31'd0, irqOut}, {31'd0, |(mPend & mEn)});
  endtask

  // Driver: one bus/line cycle, updates the model, queues read expectations
  task automatic step(logic w, logic r, logic [7:0] a, logic [31:0] d,
                      logic [NS-1:0] s, string tag);
    int idx;
    wrEn = w; rdEn = r; addr = a; wdata = d; sigIn = s;
    if (r) begin
      expQ.push_back((a == A_QRY) ? expQuery() : 32'd0);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; sigIn = '0;
    idx = slotOf(d);
    if (w) begin
      case (a)
        A_EN:    if (idx >= 0) mEn[idx] = 1'b1;
        A_DIS:   if (idx >= 0) mEn[idx] = 1'b0;
        A_ACK:   if (idx >= 0) mPend[idx] = 1'b0;
        A_FLUSH: mPend = '0;
        default: ;
      endcase
    end
    mPend = mPend | s;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b0, a, d, '0, tag);
  endtask

  task automatic rd(string tag);
    step(1'b0, 1'b1, A_QRY, 32'd0, '0, tag);
  endtask

  task automatic ring(int s, string tag);
    logic [NS-1:0] v = '0;
    v[s] = 1'b1;
    step(1'b0, 1'b0, 8'h00, 32'd0, v, tag);
  endtask

  // Monitor: compares read data the cycle after each read
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      chk(tagQ.pop_front(), rdata, expQ.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset irq", {31'd0, irqOut}, 32'd0);
    chk("R2 idle strobe", {31'd0, sendStrobe}, 32'd0);
    rd("R11 reset query");

    // R7: masked arrival stays pending, no interrupt
    ring(47, "R7");
    chk("R7 masked irq", {31'd0, irqOut}, 32'd0);
    rd("R7 masked query");
    wr(A_EN, idOf(47), "R5");
    chk("R7 unmask irq", {31'd0, irqOut}, 32'd1);
    rd("R7 query after unmask");

    // R1/R3: packing and lowest-slot priority
    wr(A_EN, 32'h0001_0005, "R5");
    ring(13, "R1");
    rd("R1 R3 lowest slot");
    chk("R1 model id", expQuery(), 32'h0001_0005);
    chkIrq("R6 two pending");

    // R9: unknown ids that alias under naive decode
    wr(A_ACK, 32'h0001_0008, "R9");
    rd("R9 ack unknown keeps slot 13");
    wr(A_EN, 32'h0000_0008, "R9");
    wr(A_EN, 32'h0006_0000, "R9");

    // R4: ack one slot only
    wr(A_ACK, idOf(13), "R4");
    rd("R4 next slot reported");
    wr(A_ACK, idOf(47), "R4");
    rd("R4 all acked");
    chk("R6 idle irq", {31'd0, irqOut}, 32'd0);

    ring(8, "R9");
    chk("R9 slot 8 stays masked", {31'd0, irqOut}, 32'd0);
    ring(40, "R9");
    chk("R9 slot 40 stays masked", {31'd0, irqOut}, 32'd0);
    wr(A_FLUSH, 32'd0, "R8");

    // R5: mask affects only the named slot
    ring(13, "R5");
    chkIrq("R6 slot 13");
    wr(A_DIS, idOf(13), "R5");
    chk("R5 masked irq", {31'd0, irqOut}, 32'd0);
    ring(47, "R5");
    chk("R5 neighbour still enabled", {31'd0, irqOut}, 32'd1);
    rd("R5 query skips masked");
    wr(A_EN, idOf(13), "R5");
    rd("R5 re-unmasked pending");

    // R8: flush clears all, keeps masks
    wr(A_FLUSH, 32'h1234_5678, "R8");
    chk("R8 flush irq", {31'd0, irqOut}, 32'd0);
    rd("R8 flush query");
    ring(13, "R8");
    chk("R8 mask kept", {31'd0, irqOut}, 32'd1);

    // R10: arrival beats clear in the same cycle
    step(1'b1, 1'b0, A_ACK, idOf(13), 48'(1) << 13, "R10");
    rd("R10 ack race");
    step(1'b1, 1'b0, A_FLUSH, 32'd0, 48'(1) << 47, "R10");
    rd("R10 flush race");

    // R2: outgoing doorbell
    wr(A_SEND, 32'h0003_0002, "R2");
    chk("R2 strobe", {31'd0, sendStrobe}, 32'd1);
    chk("R2 id", sendId, 32'h0003_0002);
    @(negedge clk);
    chk("R2 single pulse", {31'd0, sendStrobe}, 32'd0);

    // R11: reset in mid-run clears pending and masks
    chk("R11 pre-reset irq", {31'd0, irqOut}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mPend = '0; mEn = '0;
    @(negedge clk);
    chk("R11 irq after reset", {31'd0, irqOut}, 32'd0);
    wr(A_EN, idOf(47), "R11");
    chk("R11 pending cleared", {31'd0, irqOut}, 32'd0);
    ring(3, "R11");
    chk("R11 mask cleared", {31'd0, irqOut}, 32'd0);
    rd("R11 query after reset");
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule